// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block divides a fast input clock (standing in for the prescaled RF clock) by a programmable integer ratio and emits a single-clock pulse at the end of each division cycle; that pulse feeds the main phase comparator. A small modulo-Q accumulator gains the fractional numerator on every cycle boundary. Each time it wraps, the cycle that starts at that boundary is one input clock longer. Over Q cycles the average ratio is therefore the integer ratio plus numerator/Q. Q is 5 or 8, picked by a one-bit mode input.

New settings (ratio, numerator, modulus) are captured on a load strobe into a holding register. All three take effect together at the next cycle boundary, so a running cycle is never cut or extended mid-way. The accumulator value is brought out continuously so that a ripple-compensation circuit can follow the phase error it represents.

Top module: `fracn_main_div`

## Requirements
- R1: Reset puts the accumulator output at 0 and selects ratio N_RST (default 512), numerator 0 and Q=5. The first pulse after reset release is seen after the N_RST-1'th rising edge, so the first cycle spans N_RST clocks.
- R2: `div_pulse` is high for exactly one clock per division cycle. Two consecutive rising pulses are separated by the cycle length in clocks.
- R3: At each cycle boundary the accumulator becomes (acc + NF) mod Q. `acc_out` changes at no other edge.
- R4: `mod_sel`=0 selects Q=5 and `mod_sel`=1 selects Q=8. `acc_out` always stays below the selected Q.
- R5: When acc + NF reaches or exceeds Q at a boundary, the cycle beginning there lasts N+1 clocks; otherwise it lasts N clocks. Over Q such cycles, exactly NF are stretched.
- R6: With NF=0 every cycle lasts exactly N clocks and the accumulator stays at 0.
- R7: A load strobe captures `ratio_in`, `frac_in` and `mod_sel` on its clock edge. All three become active together at the first boundary after that edge; the cycle in progress keeps its length.
- R8: At the boundary where new settings take effect, the accumulator restarts from zero (it becomes NF) and the following cycle is not stretched.
- R9: A load is ignored if its ratio lies outside N_MIN..N_MAX (512..65536) or if its NF is not below the Q it selects. A load still waiting from earlier is kept unchanged.
- R10: If a second valid strobe comes before the boundary, it replaces the first one completely.
- R11: The full-scale ratio 65536 produces cycles of 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_stb | input | 1 | One-clock strobe that captures new settings |
| ratio_in | input | 17 | Integer division ratio N |
| frac_in | input | 3 | Fractional numerator NF |
| mod_sel | input | 1 | Modulus select: 0 gives Q=5, 1 gives Q=8 |
| div_pulse | output | 1 | One-clock pulse at each cycle end |
| acc_out | output | 3 | Present fractional accumulator contents |

## Verification
The hardest state to reach from the ports is a holding register that already carries a valid setting while a bad load, or a second good load, arrives before the boundary. This only matters inside the short window between a strobe and the next terminal count. The stimulus therefore waits one clock past a pulse, issues two strobes back to back, and measures the cycle that was in progress and the cycles that follow. A table of numerator and modulus pairs, including the largest numerator for each Q, runs the accumulator through complete wrap sequences. For each pair, the number of stretched cycles the design produces is compared with a hand-derived count. One final run at the 65536 ratio exercises the full counter width.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
   typedef enum logic {
      MODSEL_LO = 1'b0,
      MODSEL_HI = 1'b1
   } modsel_e;
endpackage

// File: rtl/fracn_shadow.sv
module fracn_shadow
   import fracn_pkg::*;
#(
   parameter int N_W   = 17,
   parameter int ACC_W = 3,
   parameter int N_MIN = 512,
   parameter int N_MAX = 65536,
   parameter int N_RST = 512,
   parameter int Q_LO  = 5,
   parameter int Q_HI  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_stb,
   input  logic [N_W-1:0]   n_in,
   input  logic [ACC_W-1:0] nf_in,
   input  logic             mod_in,
   input  logic             tc,
   output logic [N_W-1:0]   eff_n,
   output logic [ACC_W-1:0] eff_nf,
   output logic             eff_mod,
   output logic             act_mod,
   output logic             apply
);
   localparam logic [N_W-1:0]  N_LO_V  = N_W'(N_MIN);
   localparam logic [N_W-1:0]  N_HI_V  = N_W'(N_MAX);
   localparam logic [N_W-1:0]  N_RST_V = N_W'(N_RST);
   localparam logic [ACC_W:0]  QL      = (ACC_W+1)'(Q_LO);
   localparam logic [ACC_W:0]  QH      = (ACC_W+1)'(Q_HI);

   logic             ld_ok;
   logic [ACC_W:0]   q_req;
   logic             pend_vld;
   logic [N_W-1:0]   pend_n,   act_n;
   logic [ACC_W-1:0] pend_nf,  act_nf;
   logic             pend_mod, act_mod_q;

   always_comb begin
      q_req = (mod_in == MODSEL_HI) ? QH : QL;
      ld_ok = (n_in >= N_LO_V) && (n_in <= N_HI_V) && ({1'b0, nf_in} < q_req);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_n    <= N_RST_V;
         pend_nf   <= '0;
         pend_mod  <= MODSEL_LO;
         act_n     <= N_RST_V;
         act_nf    <= '0;
         act_mod_q <= MODSEL_LO;
      end else begin
         if (tc && pend_vld) begin
            act_n     <= pend_n;
            act_nf    <= pend_nf;
            act_mod_q <= pend_mod;
         end
         if (ld_stb && ld_ok) begin
            pend_n   <= n_in;
            pend_nf  <= nf_in;
            pend_mod <= mod_in;
            pend_vld <= 1'b1;
         end else if (tc) begin
            pend_vld <= 1'b0;
         end
      end
   end

   assign eff_n   = pend_vld ? pend_n   : act_n;
   assign eff_nf  = pend_vld ? pend_nf  : act_nf;
   assign eff_mod = pend_vld ? pend_mod : act_mod_q;
   assign act_mod = act_mod_q;
   assign apply   = tc && pend_vld;

   AST_ACT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !tc |=> ($stable(act_n) && $stable(act_nf) && $stable(act_mod_q))); // R7
   AST_BAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb && !ld_ok && !tc) |=> (pend_vld == $past(pend_vld))); // R9
   AST_EFF_NF_OK: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> ({1'b0, eff_nf} < ((eff_mod == MODSEL_HI) ? QH : QL))); // R9
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
   import fracn_pkg::*;
#(
   parameter int ACC_W = 3,
   parameter int Q_LO  = 5,
   parameter int Q_HI  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic [ACC_W-1:0] nf,
   input  logic             mod_hi,
   output logic [ACC_W-1:0] acc,
   output logic             carry
);
   localparam logic [ACC_W:0] QL      = (ACC_W+1)'(Q_LO);
   localparam logic [ACC_W:0] QH      = (ACC_W+1)'(Q_HI);
   localparam bit             HI_POW2 = (Q_HI == (1 << ACC_W));

   logic [ACC_W-1:0] base;
   logic [ACC_W:0]   sum;
   logic             lo_c, hi_c;
   logic [ACC_W-1:0] lo_n, hi_n, nxt;

   assign base = restart ? '0 : acc;
   assign sum  = {1'b0, base} + {1'b0, nf};
   assign lo_c = (sum >= QL);
   assign lo_n = lo_c ? ACC_W'(sum - QL) : sum[ACC_W-1:0];

   generate
      if (HI_POW2) begin : g_hi_wrap
         assign hi_c = sum[ACC_W];
         assign hi_n = sum[ACC_W-1:0];
      end else begin : g_hi_cmp
         assign hi_c = (sum >= QH);
         assign hi_n = hi_c ? ACC_W'(sum - QH) : sum[ACC_W-1:0];
      end
   endgenerate

   assign carry = (mod_hi == MODSEL_HI) ? hi_c : lo_c;
   assign nxt   = (mod_hi == MODSEL_HI) ? hi_n : lo_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (step) acc <= nxt;
   end

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(acc)); // R3
   AST_NF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (nf == '0) && (restart || (acc == '0))) |=> (acc == '0)); // R6
   AST_RESTART_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (step && restart) |-> !carry); // R8
endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt #(
   parameter int CNT_W      = 17,
   parameter int START      = 511,
   parameter int MIN_RELOAD = 511
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] reload,
   output logic             tc
);
   localparam logic [CNT_W-1:0] START_V = CNT_W'(START);
   localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(MIN_RELOAD);

   logic [CNT_W-1:0] cnt_q;

   assign tc = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q <= START_V;
      else if (tc) cnt_q <= reload;
      else         cnt_q <= cnt_q - 1'b1;
   end

   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> !tc); // R2
   AST_RELOAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> (cnt_q >= MIN_V)); // R1
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
   import fracn_pkg::*;
#(
   parameter int  N_MIN = 512,
   parameter int  N_MAX = 65536,
   parameter int  N_RST = 512,
   parameter int  Q_LO  = 5,
   parameter int  Q_HI  = 8,
   localparam int N_W   = $clog2(N_MAX + 1),
   localparam int ACC_W = $clog2(Q_HI)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_stb,
   input  logic [N_W-1:0]   ratio_in,
   input  logic [ACC_W-1:0] frac_in,
   input  logic             mod_sel,
   output logic             div_pulse,
   output logic [ACC_W-1:0] acc_out
);
   localparam logic [ACC_W:0] QL = (ACC_W+1)'(Q_LO);
   localparam logic [ACC_W:0] QH = (ACC_W+1)'(Q_HI);

   initial begin : g_param_chk
      assert (N_MIN >= 2 && N_MIN <= N_RST && N_RST <= N_MAX)
         else $fatal(1, "divider ratio parameters out of order");
      assert (Q_LO >= 2 && Q_LO < Q_HI)
         else $fatal(1, "modulus parameters out of order");
   end

   logic             tc;
   logic             apply;
   logic [N_W-1:0]   eff_n;
   logic [ACC_W-1:0] eff_nf;
   logic             eff_mod;
   logic             act_mod;
   logic             carry;
   logic [N_W:0]     ratio_sum;
   logic [N_W-1:0]   reload;

   fracn_shadow #(
      .N_W(N_W), .ACC_W(ACC_W), .N_MIN(N_MIN), .N_MAX(N_MAX),
      .N_RST(N_RST), .Q_LO(Q_LO), .Q_HI(Q_HI)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb),
      .n_in(ratio_in), .nf_in(frac_in), .mod_in(mod_sel), .tc(tc),
      .eff_n(eff_n), .eff_nf(eff_nf), .eff_mod(eff_mod),
      .act_mod(act_mod), .apply(apply)
   );

   fracn_accum #(
      .ACC_W(ACC_W), .Q_LO(Q_LO), .Q_HI(Q_HI)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .step(tc), .restart(apply),
      .nf(eff_nf), .mod_hi(eff_mod), .acc(acc_out), .carry(carry)
   );

   assign ratio_sum = {1'b0, eff_n} + (N_W+1)'(carry);
   assign reload    = N_W'(ratio_sum - (N_W+1)'(1));

   fracn_cnt #(
      .CNT_W(N_W), .START(N_RST - 1), .MIN_RELOAD(N_MIN - 1)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .reload(reload), .tc(tc)
   );

   assign div_pulse = tc;

   AST_ACC_LT_Q: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, acc_out} < ((act_mod == MODSEL_HI) ? QH : QL)); // R4
endmodule

// File: tb/tb_fracn_main_div.sv
module tb_fracn_main_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_stb = 1'b0;
   logic [16:0] ratio_in = '0;
   logic [2:0]  frac_in = '0;
   logic        mod_sel = 1'b0;
   logic        div_pulse;
   logic [2:0]  acc_out;

   always #5 clk = ~clk;

   fracn_main_div dut (
      .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ratio_in(ratio_in),
      .frac_in(frac_in), .mod_sel(mod_sel), .div_pulse(div_pulse), .acc_out(acc_out)
   );

   // vector table: ratio, numerator, mode, cycles after the first, expected stretched cycles
   localparam int NV = 6;
   localparam int VN[NV] = '{512, 513, 600, 520, 530, 1000};
   localparam int VF[NV] = '{0,   3,   2,   4,   7,   1};
   localparam int VM[NV] = '{0,   1,   0,   0,   1,   1};
   localparam int VC[NV] = '{4,   9,   6,   6,   9,   9};
   localparam int VS[NV] = '{0,   3,   2,   5,   8,   1};

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   // bench model of the requirements
   int m_n = 512, m_nf = 0, m_q = 5, m_acc = 0, cur_len = 512;
   bit m_pend = 0;
   int p_n = 0, p_nf = 0, p_q = 5;
   int last_len = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tc_model();
      int s;
      if (m_pend) begin
         m_n = p_n; m_nf = p_nf; m_q = p_q;
         m_acc = m_nf; cur_len = m_n; m_pend = 0;
      end else begin
         s = m_acc + m_nf;
         if (s >= m_q) begin m_acc = s - m_q; cur_len = m_n + 1; end
         else begin m_acc = s; cur_len = m_n; end
      end
   endtask

   task automatic load(input int n, input int nf, input int m);
      int q;
      q = (m != 0) ? 8 : 5;
      ratio_in = 17'(n); frac_in = 3'(nf); mod_sel = m[0]; ld_stb = 1'b1;
      if (n >= 512 && n <= 65536 && nf < q) begin
         p_n = n; p_nf = nf; p_q = q; m_pend = 1;
      end
      @(negedge clk);
      ld_stb = 1'b0;
   endtask

   // measure the cycle in progress; off = negedges of it already consumed
   task automatic cyc(input string req, input int off);
      int p;
      int a;
      int pl;
      p = 0; a = 0; pl = 0;
      do begin
         @(negedge clk);
         p++;
         if (p == 1) begin a = int'(acc_out); pl = int'(div_pulse); end
      end while (div_pulse !== 1'b1);
      chk(p + off == cur_len, req, p + off, cur_len);
      chk(a == m_acc, "R3", a, m_acc);
      if (off == 0) chk(pl == 0, "R2", pl, 0);
      last_len = p + off;
      tc_model();
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL R2 watchdog actual=no_finish expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      int st;
      repeat (3) @(negedge clk);
      chk(acc_out == 3'd0, "R1", int'(acc_out), 0);
      chk(div_pulse == 1'b0, "R1", int'(div_pulse), 0);
      rst_n = 1'b1;
      cyc("R1", 1);
      cyc("R6", 0);

      // R9: bad loads are ignored
      @(negedge clk);
      load(511, 0, 0);
      load(65537, 0, 0);
      load(600, 5, 0);
      cyc("R9", 4);
      cyc("R9", 0);
      chk(acc_out == 3'd0, "R9", int'(acc_out), 0);

      // R7 and R9: valid load then bad load in the same cycle
      @(negedge clk);
      load(700, 1, 0);
      load(900, 6, 0);
      cyc("R7", 3);
      cyc("R8", 0);
      cyc("R9", 0);

      // R10: the later valid strobe wins
      @(negedge clk);
      load(800, 2, 1);
      load(540, 3, 0);
      cyc("R7", 3);
      cyc("R10", 0);
      cyc("R10", 0);
      chk(last_len == 541, "R10", last_len, 541);

      // table walk: R4, R5
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         load(VN[i], VF[i], VM[i]);
         cyc("R7", 2);
         st = 0;
         for (int k = 0; k <= VC[i]; k++) begin
            cyc((k == 0) ? "R8" : "R5", 0);
            if (last_len == VN[i] + 1) st++;
         end
         chk(st == VS[i], "R4", st, VS[i]);
         if (VF[i] == 0) chk(acc_out == 3'd0, "R6", int'(acc_out), 0);
      end

      // R11: full-scale ratio
      @(negedge clk);
      load(65536, 0, 0);
      cyc("R7", 2);
      cyc("R11", 0);

      if (!done) begin
         done = 1;
         summary();
         $finish;
      end
   end
endmodule